// File: doc/BRIEF.md
# Block-Cipher Register Front End

This block sits between a 32-bit register port and a 64-bit block-cipher datapath. Software (or a DMA engine) loads up to six key words, an initial chaining value, a control word and a byte count. It then moves data one 8-byte block at a time: two words go in, the block is passed to the cipher core over a valid/ready stream, and the two result words come back out. The cipher rounds are not part of the block. The core is reached only through the request and response streams, and any fixed- or variable-latency transform may sit behind them.

Progress is signalled by two events that alternate. A "ready for input" event is raised when the front end is idle and bytes remain. A "result ready" event is raised when a finished block waits to be read. Each event has a status bit, an enable bit, a live flag in the control word and a gated DMA request line. The block applies CBC chaining itself, around the core: in encryption it XORs the plaintext with the chaining value before the core, and in decryption it XORs the core output with it. The byte count drops by 8 each time a result block is drained. At zero the front end stops asking for input.

Stream rules: the request stream (`ci_*`) holds `ci_valid`, `ci_data` and the mode and key outputs steady until `ci_ready` is seen high at a clock edge. The response stream is accepted only while `co_ready` is high, which happens only after a request has been taken. There is never more than one block in flight.

Top module: `bc_front`

Register offsets, each a 32-bit word: key words 0..5 at 0x00..0x14, chaining value high/low at 0x18/0x1C, control at 0x20, byte count at 0x24, data high/low at 0x28/0x2C, revision at 0x30, DMA mask at 0x34, event status at 0x3C, event enable at 0x40.

## Requirements
- R1: After reset the event status, the byte count, the control flags, `irq`, `dma_in_req`, `dma_out_req` and `ci_valid` are all zero.
- R2: When the front end is idle and the byte count is nonzero, control bit 1 (input ready) reads 1, and one cycle later status bit 1 (data-in event) is set.
- R3: A write to data low (0x2C) while input ready is set launches the block {data high, data low}, with the word written at 0x28 in bits 63:32. The request stays valid with stable data until `ci_ready`, and `co_ready` is high only after the request has been taken.
- R4: In ECB mode (control bit 4 = 0) the result words read at 0x28/0x2C equal the core output. Once the result is present, control bit 0 reads 1 and status bit 2 (data-out event) is set.
- R5: CBC encryption (control bit 4 = 1, bit 2 = 1) sends plaintext XOR chaining value to the core, and the chaining value becomes the core output.
- R6: CBC decryption (bit 4 = 1, bit 2 = 0) returns core output XOR chaining value, and the chaining value becomes the input block.
- R7: A read of 0x2C while a result is present drains the block and lowers the byte count by 8, or to 0 if the count is below 8. At zero no data-in event is raised, and data writes launch nothing.
- R8: A write to the status register keeps only the bits written as 1. A new event in the same cycle wins over the clear.
- R9: `irq` is the OR over bits 1 and 2 of status AND enable (0x40).
- R10: `dma_in_req` = mask bit 5 AND start bit 7 AND input ready. `dma_out_req` = mask bit 6 AND bit 7 AND result present.
- R11: The revision register reads the major version in bits 10:8 and the minor version in bits 5:0. Key registers read as zero.
- R12: Control bits 4:2 read back as written. Writes to bits 1:0 have no effect on them.
- R13: `ci_key` carries key words 0..5 with word 0 in the top bits, `ci_triple` equals control bit 3 and `ci_encrypt` equals control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the edge) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Event interrupt |
| dma_in_req | output | 1 | DMA request for an input block |
| dma_out_req | output | 1 | DMA request for a result block |
| ci_valid | output | 1 | Request to the cipher core valid |
| ci_ready | input | 1 | Core accepts the request |
| ci_data | output | 64 | Block sent to the core |
| ci_key | output | 192 | Six key words |
| ci_triple | output | 1 | Three-key mode |
| ci_encrypt | output | 1 | Direction, 1 = encrypt |
| co_valid | input | 1 | Core result valid |
| co_ready | output | 1 | Front end accepts the result |
| co_data | input | 64 | Core result block |

## Verification
A sequencer stuck in the wrong phase shows at once in the two control flags and in a missing or extra event in the status register, within a cycle of the register access that should have moved it. A wrong chaining value or word order shows in the very next result read, and the chaining register can be read back after every block. A count that does not step by 8 shows in the count read after each drain, and after the last block as a spurious data-in event. The sweep covers every mode combination under several core latencies and back-pressure depths.

// File: rtl/bc_front_pkg.sv
package bc_front_pkg;
  localparam logic [7:0] A_KEY0  = 8'h00;
  localparam logic [7:0] A_IVH   = 8'h18;
  localparam logic [7:0] A_IVL   = 8'h1C;
  localparam logic [7:0] A_CTRL  = 8'h20;
  localparam logic [7:0] A_LEN   = 8'h24;
  localparam logic [7:0] A_DATAH = 8'h28;
  localparam logic [7:0] A_DATAL = 8'h2C;
  localparam logic [7:0] A_REV   = 8'h30;
  localparam logic [7:0] A_MASK  = 8'h34;
  localparam logic [7:0] A_STAT  = 8'h3C;
  localparam logic [7:0] A_IEN   = 8'h40;

  typedef enum logic [1:0] {ST_IN, ST_REQ, ST_RSP, ST_OUT} seq_st_t;
endpackage

// File: rtl/bc_front_cfg.sv
module bc_front_cfg
  import bc_front_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 6,
  localparam int KEY_W    = KEY_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [KEY_W-1:0]  key_flat,
  output logic              cbc,
  output logic              triple,
  output logic              enc,
  output logic [2:0]        dma_mask,
  output logic [1:0]        ien
);
  logic [DATA_W-1:0] key_q [KEY_WORDS];

  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
    localparam logic [7:0] KADDR = A_KEY0 + 8'(4 * k);
    always_ff @(posedge clk) begin
      if (!rst_n)                       key_q[k] <= '0;
      else if (wr_en && addr == KADDR) key_q[k] <= wdata;
    end
    assign key_flat[KEY_W-1-k*DATA_W -: DATA_W] = key_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cbc, triple, enc} <= 3'b000;
      dma_mask           <= 3'b000;
      ien                <= 2'b00;
    end else if (wr_en) begin
      if (addr == A_CTRL) {cbc, triple, enc} <= wdata[4:2];
      if (addr == A_MASK) dma_mask <= wdata[7:5];
      if (addr == A_IEN)  ien <= wdata[2:1];
    end
  end
endmodule

// File: rtl/bc_front_chain.sv
module bc_front_chain #(
  parameter int BLK_W = 64
) (
  input  logic             cbc,
  input  logic             enc,
  input  logic [BLK_W-1:0] din,
  input  logic [BLK_W-1:0] iv,
  input  logic [BLK_W-1:0] core_out,
  output logic [BLK_W-1:0] to_core,
  output logic [BLK_W-1:0] from_core,
  output logic [BLK_W-1:0] iv_next
);
  always_comb begin
    to_core   = (cbc && enc)  ? (din ^ iv)      : din;
    from_core = (cbc && !enc) ? (core_out ^ iv) : core_out;
    // ciphertext is what chains forward in both directions
    iv_next   = enc ? core_out : din;
  end
endmodule

// File: rtl/bc_front_seq.sv
module bc_front_seq
  import bc_front_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  localparam int BLK_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cbc,
  input  logic              enc,
  output logic              ci_valid,
  input  logic              ci_ready,
  output logic [BLK_W-1:0]  ci_data,
  input  logic              co_valid,
  output logic              co_ready,
  input  logic [BLK_W-1:0]  co_data,
  output logic              in_rdy,
  output logic              out_rdy,
  output logic [1:0]        stat,
  output logic [BLK_W-1:0]  iv,
  output logic [BLK_W-1:0]  dout,
  output logic [LEN_W-1:0]  len
);
  localparam logic [LEN_W-1:0] BLK_BYTES = LEN_W'(BLK_W / 8);

  seq_st_t          st_q;
  logic [BLK_W-1:0] din_q;
  logic [BLK_W-1:0] to_core, from_core, iv_next;
  logic             in_prev, out_prev;
  logic             take_hi, take_lo, drain, rsp_fire;

  bc_front_chain #(.BLK_W(BLK_W)) u_chain (
    .cbc(cbc), .enc(enc), .din(din_q), .iv(iv), .core_out(co_data),
    .to_core(to_core), .from_core(from_core), .iv_next(iv_next)
  );

  assign in_rdy   = (st_q == ST_IN) && (len != '0);
  assign out_rdy  = (st_q == ST_OUT);
  assign ci_valid = (st_q == ST_REQ);
  assign co_ready = (st_q == ST_RSP);
  assign ci_data  = to_core;
  assign take_hi  = wr_en && addr == A_DATAH && in_rdy;
  assign take_lo  = wr_en && addr == A_DATAL && in_rdy;
  assign drain    = rd_en && addr == A_DATAL && out_rdy;
  assign rsp_fire = co_valid && co_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IN;
      din_q    <= '0;
      dout     <= '0;
      iv       <= '0;
      len      <= '0;
      stat     <= 2'b00;
      in_prev  <= 1'b0;
      out_prev <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IN:  if (take_lo) st_q <= ST_REQ;
        ST_REQ: if (ci_ready) st_q <= ST_RSP;
        ST_RSP: if (rsp_fire) st_q <= ST_OUT;
        ST_OUT: if (drain) st_q <= ST_IN;
        default: st_q <= ST_IN;
      endcase

      if (take_hi) din_q[BLK_W-1 -: DATA_W] <= wdata;
      if (take_lo) din_q[DATA_W-1:0]        <= wdata;

      if (wr_en && addr == A_IVH) iv[BLK_W-1 -: DATA_W] <= wdata;
      if (wr_en && addr == A_IVL) iv[DATA_W-1:0]        <= wdata;
      if (rsp_fire) begin
        dout <= from_core;
        if (cbc) iv <= iv_next;
      end

      if (wr_en && addr == A_LEN) len <= wdata[LEN_W-1:0];
      else if (drain)             len <= (len >= BLK_BYTES) ? len - BLK_BYTES : '0;

      in_prev  <= in_rdy;
      out_prev <= out_rdy;
      stat <= ((wr_en && addr == A_STAT) ? (stat & wdata[2:1]) : stat)
              | {out_rdy && !out_prev, in_rdy && !in_prev};
    end
  end
endmodule

// File: rtl/bc_front.sv
module bc_front
  import bc_front_pkg::*;
#(
  parameter int         DATA_W    = 32,
  parameter int         KEY_WORDS = 6,
  parameter int         LEN_W     = 16,
  parameter logic [2:0] REV_MAJOR = 3'd2,
  parameter logic [5:0] REV_MINOR = 6'd5,
  localparam int        BLK_W     = 2 * DATA_W,
  localparam int        KEY_W     = KEY_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              dma_in_req,
  output logic              dma_out_req,
  output logic              ci_valid,
  input  logic              ci_ready,
  output logic [BLK_W-1:0]  ci_data,
  output logic [KEY_W-1:0]  ci_key,
  output logic              ci_triple,
  output logic              ci_encrypt,
  input  logic              co_valid,
  output logic              co_ready,
  input  logic [BLK_W-1:0]  co_data
);
  logic             cbc;
  logic [2:0]       dma_mask;
  logic [1:0]       ien, stat_w;
  logic             in_rdy, out_rdy;
  logic [BLK_W-1:0] iv_w, dout_w;
  logic [LEN_W-1:0] len_w;

  bc_front_cfg #(.DATA_W(DATA_W), .KEY_WORDS(KEY_WORDS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .key_flat(ci_key), .cbc(cbc), .triple(ci_triple), .enc(ci_encrypt),
    .dma_mask(dma_mask), .ien(ien)
  );

  bc_front_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cbc(cbc), .enc(ci_encrypt),
    .ci_valid(ci_valid), .ci_ready(ci_ready), .ci_data(ci_data),
    .co_valid(co_valid), .co_ready(co_ready), .co_data(co_data),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .stat(stat_w),
    .iv(iv_w), .dout(dout_w), .len(len_w)
  );

  assign irq         = |(stat_w & ien);
  assign dma_in_req  = dma_mask[0] && dma_mask[2] && in_rdy;
  assign dma_out_req = dma_mask[1] && dma_mask[2] && out_rdy;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_IVH:   bus_rdata = iv_w[BLK_W-1 -: DATA_W];
      A_IVL:   bus_rdata = iv_w[DATA_W-1:0];
      A_CTRL:  bus_rdata = DATA_W'({cbc, ci_triple, ci_encrypt, in_rdy, out_rdy});
      A_LEN:   bus_rdata = DATA_W'(len_w);
      A_DATAH: bus_rdata = dout_w[BLK_W-1 -: DATA_W];
      A_DATAL: bus_rdata = dout_w[DATA_W-1:0];
      A_REV:   bus_rdata = DATA_W'({REV_MAJOR, 2'b00, REV_MINOR});
      A_MASK:  bus_rdata = DATA_W'({dma_mask, 5'b0});
      A_STAT:  bus_rdata = DATA_W'({stat_w, 1'b0});
      A_IEN:   bus_rdata = DATA_W'({ien, 1'b0});
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bc_front_chk.sv
module bc_front_chk
  import bc_front_pkg::*;
#(
  parameter int BLK_W = 64,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_addr,
  input logic             ci_valid,
  input logic             ci_ready,
  input logic [BLK_W-1:0] ci_data,
  input logic             co_ready,
  input logic             out_rdy,
  input logic [LEN_W-1:0] len,
  input logic             dma_in_req,
  input logic [1:0]       stat
);
  logic drain_c, len_wr_c;
  assign drain_c  = bus_rd && bus_addr == A_DATAL && out_rdy;
  assign len_wr_c = bus_wr && bus_addr == A_LEN;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ci_valid && !ci_ready |=> ci_valid && $stable(ci_data));

  p_rsp_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    co_ready |-> !ci_valid);

  p_out_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |=> stat[1]);

  p_len_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drain_c && !len_wr_c && len >= LEN_W'(8) |=> len == $past(len) - LEN_W'(8));

  p_no_dma_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len == '0 |-> !dma_in_req);
endmodule

bind bc_front bc_front_chk #(.BLK_W(BLK_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .ci_valid(ci_valid), .ci_ready(ci_ready), .ci_data(ci_data), .co_ready(co_ready),
  .out_rdy(out_rdy), .len(len_w), .dma_in_req(dma_in_req), .stat(stat_w)
);

// File: tb/sim_bc_front.sv
`timescale 1ns/1ps
module sim_bc_front;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq, dma_in_req, dma_out_req;
  logic         ci_valid, ci_triple, ci_encrypt, co_ready;
  logic         ci_ready = 1'b0, co_valid = 1'b0;
  logic [63:0]  ci_data, co_data = '0;
  logic [191:0] ci_key;

  int checks = 0, fails = 0;
  bit done = 0;
  int bp = 0, lat = 0;
  bit cur_tr = 0, cur_enc = 0;
  logic [31:0] kw [6];
  logic [31:0] v;

  always #2.5 clk = ~clk;

  bc_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_in_req(dma_in_req),
    .dma_out_req(dma_out_req), .ci_valid(ci_valid), .ci_ready(ci_ready), .ci_data(ci_data),
    .ci_key(ci_key), .ci_triple(ci_triple), .ci_encrypt(ci_encrypt),
    .co_valid(co_valid), .co_ready(co_ready), .co_data(co_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] fold(input bit tr);
    logic [63:0] f;
    f = {kw[0], kw[1]};
    if (tr) f = f ^ {kw[2], kw[3]} ^ {kw[4], kw[5]};
    return f;
  endfunction

  // cipher core model: XOR with folded key, programmable back-pressure and latency
  initial begin
    logic [63:0] held, first;
    forever begin
      @(negedge clk);
      ci_ready = 1'b0; co_valid = 1'b0;
      if (ci_valid) begin
        first = ci_data;
        for (int i = 0; i < bp; i++) begin
          @(negedge clk);
          check(ci_valid && ci_data == first, "R3 request held under back-pressure", ci_data, first);
        end
        check(ci_key == {kw[0], kw[1], kw[2], kw[3], kw[4], kw[5]}, "R13 key words", ci_key[63:0], {kw[4], kw[5]});
        check(ci_triple == cur_tr && ci_encrypt == cur_enc, "R13 mode outputs",
              {ci_triple, ci_encrypt}, {cur_tr, cur_enc});
        check(!co_ready, "R3 response not accepted before request", co_ready, 0);
        ci_ready = 1'b1; held = ci_data ^ fold(cur_tr);
        @(negedge clk); ci_ready = 1'b0;
        for (int i = 0; i < lat; i++) @(negedge clk);
        co_valid = 1'b1; co_data = held;
        @(negedge clk); co_valid = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic wait_out(output bit got);
    logic [31:0] c;
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      rd(8'h20, c);
      got = c[0];
    end
  endtask

  initial begin
    logic [63:0] p, expo, ivm, x;
    logic [31:0] hi, lo;
    bit got;
    int remain;
    for (int i = 0; i < 6; i++) kw[i] = 32'h1234_5678 ^ (i * 32'h0101_0101);
    idle(4); rst_n = 1'b1; idle(1);

    // R1 reset state
    check(irq == 0 && dma_in_req == 0 && dma_out_req == 0 && ci_valid == 0, "R1 outputs after reset",
          {irq, dma_in_req, dma_out_req, ci_valid}, 0);
    rd(8'h3C, v); check(v == 0, "R1 status", v, 0);
    rd(8'h24, v); check(v == 0, "R1 count", v, 0);
    rd(8'h20, v); check(v == 0, "R1 control", v, 0);

    // R11 revision and key read-back
    rd(8'h30, v); check(v == 32'h0000_0205, "R11 revision", v, 32'h205);
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, v); check(v == 0, "R11 key reads zero", v, 0);

    // R12 control write-back, flags not writable
    wr(8'h20, 32'h0000_001F);
    rd(8'h20, v); check(v == 32'h1C, "R12 control bits", v, 32'h1C);

    // R9 / R10 with one ECB encrypt block
    for (int i = 0; i < 6; i++) wr(8'(4 * i), kw[i]);
    cur_tr = 0; cur_enc = 1; bp = 0; lat = 1;
    wr(8'h20, 32'h4);
    wr(8'h34, 32'h20);
    wr(8'h24, 32'd8);
    idle(2);
    check(dma_in_req == 0, "R10 no request without start bit", dma_in_req, 0);
    wr(8'h34, 32'hA0);
    check(dma_in_req == 1, "R10 input request", dma_in_req, 1);
    wr(8'h40, 32'h2);
    check(irq == 1, "R9 irq on data-in", irq, 1);
    wr(8'h40, 32'h0);
    check(irq == 0, "R9 irq masked", irq, 0);
    wr(8'h28, 32'h0102_0304); wr(8'h2C, 32'h0506_0708);
    wait_out(got); check(got, "R4 result present", got, 1);
    wr(8'h34, 32'hE0);
    check(dma_out_req == 1 && dma_in_req == 0, "R10 output request", {dma_out_req, dma_in_req}, 2'b10);
    wr(8'h40, 32'h4);
    check(irq == 1, "R9 irq on data-out", irq, 1);
    wr(8'h3C, 32'h4);
    rd(8'h3C, v); check(v == 32'h4, "R8 clear keeps written bits", v, 4);
    rd(8'h28, hi); rd(8'h2C, lo);
    expo = 64'h0102_0304_0506_0708 ^ fold(0);
    check({hi, lo} == expo, "R4 ECB result", {hi, lo}, expo);
    idle(2);
    check(dma_out_req == 0 && dma_in_req == 0, "R10 requests drop at zero count",
          {dma_out_req, dma_in_req}, 0);
    wr(8'h3C, 32'h0);
    rd(8'h3C, v); check(v == 0, "R8 clear all", v, 0);
    wr(8'h34, 32'h0); wr(8'h40, 32'h0);

    // R7 count floor
    wr(8'h24, 32'd4);
    wr(8'h28, 32'h1); wr(8'h2C, 32'h2);
    wait_out(got);
    rd(8'h2C, lo);
    rd(8'h24, v); check(v == 0, "R7 count floors at zero", v, 0);

    // sweep: every mode, several latencies and back-pressure depths
    for (int m = 0; m < 8; m++) begin
      bit cbc, tr, enc;
      cbc = m[2]; tr = m[1]; enc = m[0];
      cur_tr = tr; cur_enc = enc; bp = m % 3; lat = m % 4;
      for (int i = 0; i < 6; i++) begin
        kw[i] = 32'h1234_5678 ^ (i * 32'h0101_0101) ^ (m * 32'h0011_0000);
        wr(8'(4 * i), kw[i]);
      end
      ivm = {32'hCAFE_0000 + 32'(m), 32'h0BAD_F00D ^ 32'(m)};
      wr(8'h18, ivm[63:32]); wr(8'h1C, ivm[31:0]);
      wr(8'h20, {27'b0, cbc, tr, enc, 2'b00});
      wr(8'h3C, 32'h0);
      wr(8'h24, 32'd24);
      idle(2);
      rd(8'h3C, v); check(v == 32'h2, "R2 data-in event", v, 2);
      rd(8'h20, v); check(v == {27'b0, cbc, tr, enc, 2'b10}, "R2 input-ready flag", v, {cbc, tr, enc, 2'b10});
      for (int b = 0; b < 3; b++) begin
        p = {32'hA5A5_0000 + 32'(m * 16 + b), 32'h0F0F_1000 ^ 32'(b * 7 + m)};
        wr(8'h28, p[63:32]); wr(8'h2C, p[31:0]);
        wr(8'h3C, 32'h4);
        wait_out(got); check(got, "R4 result flag", got, 1);
        rd(8'h3C, v); check(v == 32'h4, "R4 data-out event", v, 4);
        if (!cbc) expo = p ^ fold(tr);
        else if (enc) begin x = (p ^ ivm) ^ fold(tr); expo = x; ivm = x; end
        else begin expo = (p ^ fold(tr)) ^ ivm; ivm = p; end
        rd(8'h28, hi); rd(8'h2C, lo);
        check({hi, lo} == expo, cbc ? (enc ? "R5 CBC encrypt result" : "R6 CBC decrypt result") : "R4 ECB result",
              {hi, lo}, expo);
        remain = 24 - 8 * (b + 1);
        rd(8'h24, v); check(v == 32'(remain), "R7 count step", v, remain);
        rd(8'h18, hi); rd(8'h1C, lo);
        check({hi, lo} == ivm, cbc ? (enc ? "R5 chaining update" : "R6 chaining update") : "R4 chaining untouched",
              {hi, lo}, ivm);
        wr(8'h3C, 32'h2);
        rd(8'h3C, v); check(v == ((remain != 0) ? 32'h2 : 32'h0), "R8 partial clear", v, (remain != 0) ? 2 : 0);
      end
      idle(3);
      rd(8'h3C, v); check(v == 0, "R7 no data-in at zero", v, 0);
      wr(8'h28, 32'h5555_5555); wr(8'h2C, 32'hAAAA_AAAA);
      idle(4);
      check(ci_valid == 0, "R7 data ignored at zero", ci_valid, 0);
      rd(8'h20, v); check(v[1:0] == 2'b00, "R7 flags idle at zero", v[1:0], 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule